// File: doc/BRIEF.md
# Packed Halfword Multiply-Accumulate Unit

This execution unit takes two packed source operands and a 64-bit accumulator value. It forms signed 16x16 products from halfwords chosen inside each 32-bit element of the sources. It combines those products by a sum, a difference, a reversed difference, or a negated sum, and adds the combined value to the accumulator. An 11-way operation code selects the halfword pairing and the signs. The XLEN parameter chooses the source width. At 32 bits there is one element. At 64 bits there are two elements, and the contributions of both are folded into the one accumulator.

The result is returned as two 32-bit halves. The low half is meant for the even register of a register pair and the high half for the odd register, so a 32-bit register file can write the 64-bit value back as a pair. Operands enter on a valid/ready handshake. The unit registers them, and the result is offered on a second valid/ready handshake one cycle later.

Back-pressure rules: the output holds its valid and its data, unchanged, until it is taken. The single internal stage accepts a new operation only when it is empty or when its current result is being taken in the same cycle.

Top module: `pmac64`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, and `out_valid` stays low during reset.
- R2: `in_ready` is high exactly when the stage is empty or `out_ready` is high. An operation accepted at a clock edge produces `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_lo` and `out_hi` hold.
- R3: Code 0 (self product) adds, for each element, bottom(b) x top(b) to the accumulator. `in_src_a` has no effect on the result in this mode.
- R4: Codes 1, 2 and 3 add, per element, bottom(a) x bottom(b), bottom(a) x top(b) and top(a) x top(b) respectively.
- R5: Code 4 adds bottom(a) x bottom(b) + top(a) x top(b). Code 5 adds top(a) x bottom(b) + bottom(a) x top(b).
- R6: Code 6 adds top(a) x top(b) - bottom(a) x bottom(b). Code 7 adds bottom(a) x bottom(b) - top(a) x top(b). Code 8 adds top(a) x bottom(b) - bottom(a) x top(b).
- R7: Code 9 subtracts bottom(a) x bottom(b) + top(a) x top(b) from the accumulator. Code 10 subtracts top(a) x bottom(b) + bottom(a) x top(b).
- R8: Halfwords and the accumulator are signed two's complement. Products and per-element combinations never wrap: (-32768) x (-32768) gives +2^30, and the sum of two such products gives +2^31.
- R9: The final accumulate is taken modulo 2^64.
- R10: In an element, bottom is bits 15:0 and top is bits 31:16. With XLEN=64, element 0 is bits 31:0 and element 1 is bits 63:32, and the contributions of both are summed. `out_lo` carries result bits 31:0 and `out_hi` carries bits 63:32.
- R11: Codes 11 to 15 return the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_op | input | 4 | Operation code |
| in_src_a | input | XLEN | First packed source |
| in_src_b | input | XLEN | Second packed source |
| in_acc | input | 64 | Accumulator input |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_lo | output | 32 | Result bits 31:0 (even register) |
| out_hi | output | 32 | Result bits 63:32 (odd register) |

## Verification
The assertions assume that `rst` is high at the first clock edge and that `out_ready` is a defined level in every cycle. The hold check also relies on the consumer not expecting the data to change during a stall. The stimulus keeps `rst` asserted for several cycles from time zero. Every input is driven on the falling edge only, and `out_ready` toggles at random so that stalls and back-to-back acceptances both occur. Operands are random, with halfwords weighted toward 0x8000, 0x7FFF, 0xFFFF and 0. Accumulators are weighted toward the two 64-bit signed extremes, so that the exact-product and wrap-around cases are exercised at both widths.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

  localparam int HW_W   = 16;
  localparam int ELEM_W = 2 * HW_W;
  localparam int LANE_W = ELEM_W + 2;

  localparam logic [3:0] OPC_SELF  = 4'd0;
  localparam logic [3:0] OPC_BB    = 4'd1;
  localparam logic [3:0] OPC_BT    = 4'd2;
  localparam logic [3:0] OPC_TT    = 4'd3;
  localparam logic [3:0] OPC_DA    = 4'd4;
  localparam logic [3:0] OPC_XDA   = 4'd5;
  localparam logic [3:0] OPC_DS    = 4'd6;
  localparam logic [3:0] OPC_RDS   = 4'd7;
  localparam logic [3:0] OPC_XDS   = 4'd8;
  localparam logic [3:0] OPC_SLDA  = 4'd9;
  localparam logic [3:0] OPC_XSLDA = 4'd10;

  typedef enum logic [1:0] {SEL_ALO, SEL_AHI, SEL_BLO, SEL_BHI} hw_sel_e;

  typedef struct packed {
    hw_sel_e x0;
    hw_sel_e y0;
    hw_sel_e x1;
    hw_sel_e y1;
    logic    en0;
    logic    en1;
    logic    neg0;
    logic    neg1;
  } pmac_ctl_t;

  function automatic pmac_ctl_t pmac_decode(input logic [3:0] op);
    pmac_ctl_t c;
    c = '{x0: SEL_ALO, y0: SEL_BLO, x1: SEL_AHI, y1: SEL_BHI,
          en0: 1'b0, en1: 1'b0, neg0: 1'b0, neg1: 1'b0};
    case (op)
      OPC_SELF:  begin c.x0 = SEL_BLO; c.y0 = SEL_BHI; c.en0 = 1'b1; end
      OPC_BB:    begin c.en0 = 1'b1; end
      OPC_BT:    begin c.y0 = SEL_BHI; c.en0 = 1'b1; end
      OPC_TT:    begin c.x0 = SEL_AHI; c.y0 = SEL_BHI; c.en0 = 1'b1; end
      OPC_DA:    begin c.en0 = 1'b1; c.en1 = 1'b1; end
      OPC_XDA:   begin c.x0 = SEL_AHI; c.x1 = SEL_ALO; c.en0 = 1'b1; c.en1 = 1'b1; end
      OPC_DS:    begin c.en0 = 1'b1; c.en1 = 1'b1; c.neg0 = 1'b1; end
      OPC_RDS:   begin c.en0 = 1'b1; c.en1 = 1'b1; c.neg1 = 1'b1; end
      OPC_XDS:   begin c.x0 = SEL_AHI; c.x1 = SEL_ALO; c.en0 = 1'b1; c.en1 = 1'b1;
                       c.neg1 = 1'b1; end
      OPC_SLDA:  begin c.en0 = 1'b1; c.en1 = 1'b1; c.neg0 = 1'b1; c.neg1 = 1'b1; end
      OPC_XSLDA: begin c.x0 = SEL_AHI; c.x1 = SEL_ALO; c.en0 = 1'b1; c.en1 = 1'b1;
                       c.neg0 = 1'b1; c.neg1 = 1'b1; end
      default:   ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmac_lane.sv
module pmac_lane
  import pmac_pkg::*;
(
  input  logic [ELEM_W-1:0]        elem_a,
  input  logic [ELEM_W-1:0]        elem_b,
  input  pmac_ctl_t                ctl,
  output logic signed [LANE_W-1:0] delta
);

  logic signed [HW_W-1:0]   x0, y0, x1, y1;
  logic signed [ELEM_W-1:0] prod0, prod1;
  logic signed [LANE_W-1:0] term0, term1;

  function automatic logic signed [HW_W-1:0] pick(input hw_sel_e s,
                                                   input logic [ELEM_W-1:0] a,
                                                   input logic [ELEM_W-1:0] b);
    case (s)
      SEL_ALO: return $signed(a[HW_W-1:0]);
      SEL_AHI: return $signed(a[ELEM_W-1:HW_W]);
      SEL_BLO: return $signed(b[HW_W-1:0]);
      default: return $signed(b[ELEM_W-1:HW_W]);
    endcase
  endfunction

  always_comb begin
    x0 = pick(ctl.x0, elem_a, elem_b);
    y0 = pick(ctl.y0, elem_a, elem_b);
    x1 = pick(ctl.x1, elem_a, elem_b);
    y1 = pick(ctl.y1, elem_a, elem_b);
    prod0 = x0 * y0;
    prod1 = x1 * y1;
    term0 = ctl.en0 ? (ctl.neg0 ? -LANE_W'(prod0) : LANE_W'(prod0)) : '0;
    term1 = ctl.en1 ? (ctl.neg1 ? -LANE_W'(prod1) : LANE_W'(prod1)) : '0;
    delta = term0 + term1;
  end

endmodule

// File: rtl/pmac64.sv
module pmac64
  import pmac_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int ACC_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [3:0]          in_op,
  input  logic [XLEN-1:0]     in_src_a,
  input  logic [XLEN-1:0]     in_src_b,
  input  logic [ACC_W-1:0]    in_acc,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ACC_W/2-1:0]  out_lo,
  output logic [ACC_W/2-1:0]  out_hi
);

  localparam int NLANE = XLEN / ELEM_W;
  localparam int HALF  = ACC_W / 2;
  localparam int SUM_W = LANE_W + $clog2(NLANE) + 1;

  logic              vld_q;
  logic [3:0]        op_q;
  logic [XLEN-1:0]   a_q, b_q;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  result;
  pmac_ctl_t         ctl;
  logic signed [LANE_W-1:0] lane_delta [NLANE];
  logic signed [SUM_W-1:0]  lane_sum;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      op_q  <= in_op;
      a_q   <= in_src_a;
      b_q   <= in_src_b;
      acc_q <= in_acc;
    end
  end

  assign ctl = pmac_decode(op_q);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    pmac_lane u_lane (
      .elem_a (a_q[g*ELEM_W +: ELEM_W]),
      .elem_b (b_q[g*ELEM_W +: ELEM_W]),
      .ctl    (ctl),
      .delta  (lane_delta[g])
    );

    // per-element combination must stay within +/-2^31 (no intermediate wrap)
    assert_lane_bound_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (lane_delta[g] <= 34'sh0_8000_0000) &&
                    (lane_delta[g] >= -34'sh0_8000_0000));
  end

  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < NLANE; i++) begin
      lane_sum = lane_sum + SUM_W'(lane_delta[i]);
    end
    result = acc_q + ACC_W'(lane_sum);
  end

  assign out_lo = result[HALF-1:0];
  assign out_hi = result[ACC_W-1:HALF];

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_accept_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_lo) && $stable(out_hi));

  assert_illegal_passthru_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && (op_q > OPC_XSLDA) |-> {out_hi, out_lo} == acc_q);

endmodule

// File: tb/pmac64_bench.sv
`timescale 1ns/1ps
module pmac64_bench;

  typedef struct {
    logic [63:0] v;
    string       t;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [3:0]  in_op = '0;
  logic [63:0] src_a = '0, src_b = '0, acc = '0;
  logic        rdy64, rdy32, ov64, ov32;
  logic [31:0] lo64, hi64, lo32, hi32;
  int          n_cmp = 0, n_bad = 0;
  exp_t        q64[$], q32[$];

  always #4 clk = ~clk;

  pmac64 #(.XLEN(64)) u_pmac64 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy64), .in_op(in_op),
    .in_src_a(src_a), .in_src_b(src_b), .in_acc(acc), .out_valid(ov64),
    .out_ready(out_ready), .out_lo(lo64), .out_hi(hi64));

  pmac64 #(.XLEN(32)) u_pmac64_n (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy32), .in_op(in_op),
    .in_src_a(src_a[31:0]), .in_src_b(src_b[31:0]), .in_acc(acc), .out_valid(ov32),
    .out_ready(out_ready), .out_lo(lo32), .out_hi(hi32));

  function automatic logic [63:0] ref_mac(int op, logic [63:0] a, logic [63:0] b,
                                          logic [63:0] c, int nel);
    longint s = 0;
    for (int e = 0; e < nel; e++) begin
      longint al = longint'($signed(a[32*e +: 16]));
      longint ah = longint'($signed(a[32*e+16 +: 16]));
      longint bl = longint'($signed(b[32*e +: 16]));
      longint bh = longint'($signed(b[32*e+16 +: 16]));
      case (op)
        0:  s += bl * bh;
        1:  s += al * bl;
        2:  s += al * bh;
        3:  s += ah * bh;
        4:  s += al * bl + ah * bh;
        5:  s += ah * bl + al * bh;
        6:  s += ah * bh - al * bl;
        7:  s += al * bl - ah * bh;
        8:  s += ah * bl - al * bh;
        9:  s -= al * bl + ah * bh;
        10: s -= ah * bl + al * bh;
        default: ;
      endcase
    end
    return c + s;
  endfunction

  function automatic string tag_of(int op);
    if (op == 0) return "R3";
    if (op <= 3) return "R4";
    if (op <= 5) return "R5";
    if (op <= 8) return "R6";
    if (op <= 10) return "R7";
    return "R11";
  endfunction

  function automatic logic [15:0] rhw();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic iv, int op, logic [63:0] a, logic [63:0] b,
                       logic [63:0] c, logic ordy, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = iv; in_op = 4'(op); src_a = a; src_b = b; acc = c; out_ready = ordy;
    #1;
    check("R2 valid64", {63'd0, ov64}, {63'd0, q64.size() != 0});
    check("R2/R10 valid32", {63'd0, ov32}, {63'd0, q32.size() != 0});
    if (ov64 && q64.size() != 0) check(q64[0].t, {hi64, lo64}, q64[0].v);
    if (ov32 && q32.size() != 0) check({q32[0].t, "/R10"}, {hi32, lo32}, q32[0].v);
    if (ov64 && out_ready && q64.size() != 0) void'(q64.pop_front());
    if (ov32 && out_ready && q32.size() != 0) void'(q32.pop_front());
    if (in_valid && rdy64) begin e.v = ref_mac(op, a, b, c, 2); e.t = tag; q64.push_back(e); end
    if (in_valid && rdy32) begin e.v = ref_mac(op, a, b, c, 1); e.t = tag; q32.push_back(e); end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 idle64", {63'd0, ov64}, 64'd0);
    check("R1 idle32", {63'd0, ov32}, 64'd0);
    // directed corners
    cycle(1, 4, 64'h8000800080008000, 64'h8000800080008000, 64'd0, 1, "R8 da_min");
    cycle(1, 9, 64'h8000800080008000, 64'h8000800080008000, 64'd5, 1, "R8 slda_min");
    cycle(1, 8, 64'h7FFF80007FFF8000, 64'h80007FFF80007FFF, 64'd0, 1, "R8 xds");
    cycle(1, 1, 64'h0001000100010001, 64'h0001000100010001,
          64'h7FFFFFFFFFFFFFFF, 1, "R9 wrap_up");
    cycle(1, 10, 64'h7FFF7FFF7FFF7FFF, 64'h7FFF7FFF7FFF7FFF,
          64'h8000000000000000, 1, "R9 wrap_down");
    cycle(1, 0, 64'hFFFFFFFFFFFFFFFF, 64'h7FFF80008000FFFF, 64'd100, 1, "R3 self_a_ignored");
    cycle(1, 0, 64'h0, 64'h7FFF80008000FFFF, 64'd100, 1, "R3 self_a_zero");
    cycle(1, 15, 64'h1234567812345678, 64'h7FFF7FFF7FFF7FFF, 64'hDEADBEEF01234567, 1, "R11");
    for (int op = 0; op < 11; op++)
      cycle(1, op, 64'h8000800080008000, 64'h8000800080008000, 64'd0, 1, tag_of(op));
    // random traffic with stalls
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] c;
      int op;
      op = int'($urandom % 16);
      case ($urandom % 4)
        0: c = 64'h7FFFFFFFFFFFFFFF;
        1: c = 64'h8000000000000000;
        default: c = {$urandom, $urandom};
      endcase
      cycle(($urandom % 4) != 0, op, {rhw(), rhw(), rhw(), rhw()},
            {rhw(), rhw(), rhw(), rhw()}, c, ($urandom % 10) < 7, tag_of(op));
    end
    for (int i = 0; i < 4; i++) cycle(0, 0, 64'd0, 64'd0, 64'd0, 1, "R2 drain");
    summary();
    $finish;
  end

endmodule